// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block reports how fast an on-chip clock is running. One clock is chosen from either of two groups of monitored clocks. The block then counts rising edges of that clock over a window of a fixed number of cycles of a trusted reference clock (26 MHz in the intended use, so kHz = count × 26000 / 1024 with the default window). The count is passed back into the reference domain, where software reads it.

Software programs the source select, and optionally a halving pre-divider. It then writes the enable bit alone, followed by enable plus start. It polls the start bit, which reads 1 while a measurement is running and clears by itself once the result is final. Writing the control register with the enable bit clear aborts any run and returns the meter to idle. A stopped or unrouted clock cannot hang the meter: a timeout after the window ends the run with a zero count.

Registers sit at word addresses 0 (control), 1 (source select), 2 (pre-divide) and 3 (result). Writes go through `wr_en`/`wr_addr`/`wr_data`. Reads are combinational through `rd_addr`/`rd_data`.

Top module: `refwin_freq_meter`

## Requirements
- R1: After a synchronous active-high reset, all four registers read 0 and the meter is idle.
- R2: The source-select (address 1) and pre-divide (address 2) registers read back the full 32-bit value last written. A write to the result register (address 3) leaves it unchanged.
- R3: A control write with bit 12 (enable) and bit 4 (start) both set, while idle, starts a measurement. Bit 4 reads 1 from the next cycle on. A control write with bit 4 set but bit 12 clear starts nothing, and bit 4 reads 0.
- R4: The counting window lasts exactly WIN reference cycles (default 1024), so bit 4 stays 1 for more than WIN cycles after a start.
- R5: When source-select bits 1:0 are 01, the measured clock is clk_a[bits 13:8]. Bits 21:16 have no effect.
- R6: When source-select bits 1:0 are 00, the measured clock is clk_b[bits 21:16].
- R7: When pre-divide bits 31:24 equal exactly 1, the measured clock is halved before counting. Any other value counts it undivided.
- R8: The result register holds the rising-edge count of the measured clock during the window in bits 15:0, within ±2 for synchronization, with bits 31:16 zero.
- R9: The count saturates at 0xFFFF rather than wrapping.
- R10: If the measured clock is stopped, or bits 1:0 are 10 or 11 (no clock routed), the result is 0. Bit 4 still clears within WIN + TMO + 6 cycles of the start.
- R11: A control write with bit 12 clear makes bits 12 and 4 read 0 on the next cycle, and leaves the result unchanged.
- R12: Bit 4 clears by itself when the result is final. The result changes only in the cycle that ends a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| clk_a | input | NA | First group of monitored clocks |
| clk_b | input | NB | Second group of monitored clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |

## Verification
The bench aims at the edges of the measured range:
- A clock fast enough to overflow 16 bits must read 0xFFFF. A wrapping counter would report a small number.
- A stopped clock and an unrouted select must both end with a zero count and a cleared start bit. A meter without the timeout would leave the bit stuck at 1 forever.
- Pre-divide values 1 and 2 are both tried. A decoder that tested a single bit or any non-zero value would halve the wrong one.

It also aborts a run partway through. This shows that the abort leaves the old result in place, and that the late handshake from the measured domain neither corrupts the result nor blocks the next run. On every cycle of every run, the start bit is compared against the window and timeout bounds.

// File: rtl/refwin_freq_meter.sv
module refwin_freq_meter #(
  parameter int NA  = 64,
  parameter int NB  = 64,
  parameter int WIN = 1024,
  parameter int TMO = 64,
  parameter int CW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NA-1:0] clk_a,
  input  logic [NB-1:0] clk_b,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    rd_addr,
  output logic [31:0]   rd_data
);
  localparam int WW = $clog2(WIN + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic [31:0]   src_q, div_q;
  logic          en_q, busy_q, run_q;
  logic [CW-1:0] res_q;
  logic [WW-1:0] win_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          req_s1, req_s2, req_d, ack_q;

  logic          sel_clk, div_t, meas_clk;
  logic          rm1, rm2, g1, g2, g3, a1, a2, req_m;
  logic [CW-1:0] cnt_m;

  wire [1:0] route  = src_q[1:0];
  wire [5:0] sel_a  = src_q[13:8];
  wire [5:0] sel_b  = src_q[21:16];
  wire       div_on = (div_q[31:24] == 8'd1);
  wire       we_ctl = wr_en && (wr_addr == 2'd0);
  wire       go     = we_ctl && wr_data[12] && wr_data[4] && !busy_q;
  wire       abort  = we_ctl && !wr_data[12];
  wire       req_up = req_s2 && !req_d;

  always_comb begin
    sel_clk = 1'b0;
    if (route == 2'b01 && int'(sel_a) < NA)
      sel_clk = clk_a[sel_a];
    else if (route == 2'b00 && int'(sel_b) < NB)
      sel_clk = clk_b[sel_b];
  end

  always_ff @(posedge sel_clk) div_t <= ~div_t;

  assign meas_clk = div_on ? div_t : sel_clk;

  always_ff @(posedge meas_clk) begin
    rm1 <= rst;
    rm2 <= rm1;
    if (rm2) begin
      g1 <= 1'b0; g2 <= 1'b0; g3 <= 1'b0;
      a1 <= 1'b0; a2 <= 1'b0;
      req_m <= 1'b0;
      cnt_m <= '0;
    end else begin
      g1 <= run_q;
      g2 <= g1;
      g3 <= g2;
      a1 <= ack_q;
      a2 <= a1;
      if (g2 && !g3)
        cnt_m <= CW'(1);
      else if (g2 && cnt_m != CMAX)
        cnt_m <= cnt_m + 1'b1;
      if (!g2 && g3)
        req_m <= 1'b1;
      else if (a2)
        req_m <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; div_q <= '0;
      en_q <= 1'b0; busy_q <= 1'b0; run_q <= 1'b0;
      res_q <= '0; win_cnt <= '0; tmo_cnt <= '0;
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_d <= 1'b0; ack_q <= 1'b0;
    end else begin
      req_s1 <= req_m;
      req_s2 <= req_s1;
      req_d  <= req_s2;
      ack_q  <= req_s2;
      if (wr_en && wr_addr == 2'd1) src_q <= wr_data;
      if (wr_en && wr_addr == 2'd2) div_q <= wr_data;
      if (we_ctl) en_q <= wr_data[12];
      if (abort) begin
        busy_q <= 1'b0;
        run_q  <= 1'b0;
      end else if (go) begin
        busy_q  <= 1'b1;
        run_q   <= 1'b1;
        win_cnt <= '0;
      end else if (run_q) begin
        win_cnt <= win_cnt + 1'b1;
        if (win_cnt == WW'(WIN - 1)) begin
          run_q   <= 1'b0;
          tmo_cnt <= '0;
        end
      end else if (busy_q) begin
        if (req_up) begin
          res_q  <= cnt_m;
          busy_q <= 1'b0;
        end else if (tmo_cnt == TW'(TMO)) begin
          res_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {19'b0, en_q, 7'b0, busy_q, 4'b0};
      2'd1:    rd_data = src_q;
      2'd2:    rd_data = div_q;
      default: rd_data = {{(32 - CW){1'b0}}, res_q};
    endcase
  end
endmodule

// File: rtl/refwin_freq_meter_chk.sv
module refwin_freq_meter_chk #(
  parameter int WIN = 1024,
  parameter int TMO = 64,
  parameter int CW  = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [31:0]   wr_data,
  input logic          busy,
  input logic          en,
  input logic          run,
  input logic [CW-1:0] res
);
  int run_len;
  int wait_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= 0;
      wait_len <= 0;
    end else begin
      run_len  <= run ? run_len + 1 : 0;
      wait_len <= (busy && !run) ? wait_len + 1 : 0;
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && wr_data[12] && wr_data[4] && !busy) |=> busy);

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && !wr_data[12]) |=> (!busy && !en));

  // R11
  busy_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> en);

  // R4
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(run) && busy) |-> (run_len == WIN));

  // R10
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wait_len <= TMO + 1);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> $stable(res));
endmodule

bind refwin_freq_meter refwin_freq_meter_chk #(.WIN(WIN), .TMO(TMO), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy_q), .en(en_q), .run(run_q), .res(res_q)
);

// File: tb/refwin_freq_meter_test.sv
`timescale 1ns/1ps
module refwin_freq_meter_test;
  localparam int WIN = 1024;
  localparam int TMO = 64;

  logic        clk = 1'b0, rst = 1'b1;
  logic [63:0] ca, cb;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  logic ca1 = 0, ca2 = 0, cb0 = 0, cb1 = 0, fast_on = 0;
  int total = 0, bad = 0, cyc = 0;

  assign ca = {60'b0, 1'b0, ca2, ca1, 1'b0};
  assign cb = {62'b0, cb1, cb0};

  refwin_freq_meter uut (
    .clk(clk), .rst(rst), .clk_a(ca), .clk_b(cb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;
  always #5.0 ca2 = ~ca2;
  always #3.5 cb1 = ~cb1;
  always #4.5 cb0 = ~cb0;
  always begin
    wait (fast_on);
    #0.038 ca1 = ~ca1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #0.5 v = rd_data;
  endtask

  task automatic measure(input int exp, input int tol, input string tag);
    logic [31:0] v;
    int n;
    bit early, hung;
    repeat (20) @(negedge clk);
    wr(0, 32'h1000);
    wr(0, 32'h1010);
    rd_addr = 2'd0;
    #0.5;
    chk(rd_data[4] == 1'b1, {tag, " R3 busy after start"}, rd_data[4], 1);
    n = 1; early = 0; hung = 0;
    forever begin
      @(negedge clk);
      n++;
      #0.5;
      if (!rd_data[4]) break;
      if (n > WIN + TMO + 6) begin hung = 1; break; end
    end
    early = (n <= WIN);
    chk(!early, {tag, " R4 window length"}, n, WIN + 1);
    chk(!hung, {tag, " R10/R12 busy self-clear"}, n, WIN + TMO + 6);
    rd(3, v);
    chk(v[31:16] == 0 && int'(v) >= exp - tol && int'(v) <= exp + tol,
        {tag, " count"}, v, exp);
    wr(0, 32'h0);
  endtask

  logic [31:0] v, keep;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R1 reset value", v, 0);
    end

    wr(1, 32'hA5C3_0F01); rd(1, v);
    chk(v == 32'hA5C3_0F01, "R2 src readback", v, 32'hA5C3_0F01);
    wr(2, 32'h0300_00FF); rd(2, v);
    chk(v == 32'h0300_00FF, "R2 div readback", v, 32'h0300_00FF);
    wr(2, 32'h0);
    wr(3, 32'h1234); rd(3, v);
    chk(v == 0, "R2 result not writable", v, 0);

    wr(0, 32'h0010); rd(0, v);
    chk(v == 0, "R3 start without enable", v, 0);
    repeat (5) @(negedge clk);
    rd(0, v);
    chk(v == 0, "R3 still idle", v, 0);

    wr(1, (32'd1 << 16) | (32'd2 << 8) | 32'd1);
    measure(512, 2, "R5 groupA sel2");

    wr(1, (32'd1 << 16) | (32'd3 << 8));
    measure(731, 2, "R6 groupB sel1");

    wr(2, 32'h0100_0000);
    measure(366, 2, "R7 prediv 1");
    wr(2, 32'h0200_0000);
    measure(731, 2, "R7 prediv 2 ignored");
    wr(2, 32'h0);

    wr(1, (32'd3 << 8) | 32'd1);
    measure(0, 0, "R10 stopped clock");
    wr(1, (32'd2 << 8) | 32'd2);
    measure(0, 0, "R10 unrouted");

    fast_on = 1'b1;
    wr(1, (32'd1 << 8) | 32'd1);
    measure(65535, 0, "R9 saturation");
    fast_on = 1'b0;

    wr(1, (32'd2 << 8) | 32'd1);
    measure(512, 2, "R8 groupA sel2");
    rd(3, keep);
    wr(1, (32'd1 << 16) | 32'd0);
    wr(0, 32'h1000);
    wr(0, 32'h1010);
    repeat (100) @(negedge clk);
    wr(0, 32'h0);
    rd(0, v);
    chk(v == 0, "R11 abort clears control", v, 0);
    repeat (60) @(negedge clk);
    rd(3, v);
    chk(v == keep, "R11 result kept after abort", v, keep);

    wr(1, (32'd2 << 8) | 32'd1);
    measure(512, 2, "R12 after abort");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule